// File: doc/BRIEF.md
# Token-Chained Pixel Hit Serializer

This block is the readout stage of one pixel readout chip in a daisy chain of chips. It waits for the readout token. When the token arrives, it sends a three-symbol chip header. It then drains its hit FIFO, turning each stored hit into six symbols: two column digits, three row digits and one pulse-height slot. When the FIFO is empty at a hit boundary, it passes the token on as a single-cycle pulse to the next chip.

Only stored hits are sent, so the stream is zero-suppressed. A chip with no hits still sends its header. Every symbol leaves as a digital kind code plus a data field; turning symbols into analog levels is done further downstream. A pixel address is 15 bits, sent as five 3-bit digits, and the pulse height is 8 bits, so each hit carries 23 bits of information.

Top module: `pix_token_serializer`

## Requirements
- R1: While reset is asserted and after it is released with no token, `sym_valid_o`, `tok_out_o` and `fifo_rd_o` are all 0.
- R2: A token sampled high while the block is idle starts the header on the next cycle. The header is three consecutive symbols with kind codes 0 (ultra-black), 1 (black) and 2 (level reference), each with data 0.
- R3: Each hit is sent as six consecutive symbols. The first five have kind code 3 and carry, in the low 3 bits of the data field with the upper bits zero, col[5:3], col[2:0], row[8:6], row[5:3] and row[2:0], in that order.
- R4: The sixth symbol of each hit has kind code 4 and carries the full 8-bit pulse height.
- R5: `fifo_rd_o` is high in exactly the first symbol cycle of each hit. Hits go out in FIFO order, and the readout stops at the first hit boundary (after the header or after a hit) at which the FIFO is empty.
- R6: `tok_out_o` is high for exactly one cycle: the cycle right after the last header or hit symbol. `sym_valid_o` is 0 in that cycle.
- R7: A token input that arrives from the first header cycle through the token-out cycle is ignored and starts no new header.
- R8: `sym_valid_o` is 1 in every header and hit symbol cycle, with no gaps, and 0 otherwise.
- R9: An entry written into the FIFO during a readout is sent in the same readout if the FIFO is non-empty at a later hit boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tok_in_i | input | 1 | Readout token from the previous chip |
| fifo_empty_i | input | 1 | Hit FIFO holds no entry |
| fifo_col_i | input | 6 | Column of the FIFO head entry |
| fifo_row_i | input | 9 | Row of the FIFO head entry |
| fifo_ph_i | input | 8 | Pulse height of the FIFO head entry |
| fifo_rd_o | output | 1 | Pop the FIFO head at this clock edge |
| sym_valid_o | output | 1 | A symbol is present this cycle |
| sym_kind_o | output | 3 | Symbol kind code |
| sym_data_o | output | 8 | Digit value or pulse height |
| tok_out_o | output | 1 | Token pulse to the next chip |

## Verification
The assertions rely on three properties of the FIFO:
- the FIFO is show-ahead, so the head fields are valid whenever it is not empty;
- entries leave only when the block pops them;
- the block never pops while the FIFO reports empty.

The bench models the FIFO as a ring whose read pointer moves only on `fifo_rd_o` and whose entries are written only between edges. That keeps the head stable during each hit's first cycle. Token pulses are driven both while the block is idle and while it is busy, and the expected stream is rebuilt by arithmetic from the hits the bench wrote.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  typedef enum logic [2:0] {
    SYM_UBLACK = 3'd0,
    SYM_BLACK  = 3'd1,
    SYM_LEVREF = 3'd2,
    SYM_ADDR   = 3'd3,
    SYM_PULSE  = 3'd4
  } sym_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_HIT  = 2'd2,
    ST_PASS = 2'd3
  } seq_state_e;

  localparam int HDR_LEN = 3;
endpackage

// File: rtl/pxs_rst_sync.sv
module pxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/pxs_sequencer.sv
module pxs_sequencer
  import pxs_pkg::*;
#(
  parameter int HIT_SYMS = 6,
  parameter int PHASE_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tok_in_i,
  input  logic               fifo_empty_i,
  output seq_state_e         state_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               load_o,
  output logic               busy_o,
  output logic               tok_out_o
);
  seq_state_e         state_q, state_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               phase_en;
  logic               hdr_last, hit_last;

  assign hdr_last = (phase_q == PHASE_W'(HDR_LEN - 1));
  assign hit_last = (phase_q == PHASE_W'(HIT_SYMS - 1));

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    phase_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tok_in_i) begin
          state_d  = ST_HDR;
          phase_d  = '0;
          phase_en = 1'b1;
        end
      end
      ST_HDR, ST_HIT: begin
        phase_en = 1'b1;
        if ((state_q == ST_HDR && hdr_last) || (state_q == ST_HIT && hit_last)) begin
          phase_d = '0;
          state_d = fifo_empty_i ? ST_PASS : ST_HIT;
        end else begin
          phase_d = phase_q + PHASE_W'(1);
        end
      end
      ST_PASS: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign state_o   = state_q;
  assign phase_o   = phase_q;
  assign load_o    = (state_q == ST_HIT) && (phase_q == '0);
  assign busy_o    = (state_q != ST_IDLE);
  assign tok_out_o = (state_q == ST_PASS);

  // R6: the token handed on lasts one cycle
  assert_tok_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_out_o |=> !tok_out_o);

  // R3: a hit never runs past its last symbol slot
  assert_hit_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT) |-> (phase_q < PHASE_W'(HIT_SYMS)));

  // R2: the header always runs its full length before hits or token-out
  assert_hdr_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR && !hdr_last) |=> (state_q == ST_HDR));
endmodule

// File: rtl/pxs_hit_slicer.sv
module pxs_hit_slicer
  import pxs_pkg::*;
#(
  parameter int COL_DIGITS = 2,
  parameter int ROW_DIGITS = 3,
  parameter int DIGIT_W    = 3,
  parameter int PH_W       = 8,
  parameter int PHASE_W    = 3,
  localparam int COL_W       = COL_DIGITS * DIGIT_W,
  localparam int ROW_W       = ROW_DIGITS * DIGIT_W,
  localparam int ADDR_DIGITS = COL_DIGITS + ROW_DIGITS,
  localparam int ADDR_W      = COL_W + ROW_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  seq_state_e         state_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               load_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [PH_W-1:0]    ph_i,
  output logic               valid_o,
  output sym_kind_e          kind_o,
  output logic [PH_W-1:0]    data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [PH_W-1:0]   ph_q;
  logic [ADDR_W-1:0] addr_src;
  logic [PH_W-1:0]   ph_src;
  logic [DIGIT_W-1:0] digit [ADDR_DIGITS];

  // latch the head entry in the cycle it is popped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ph_q   <= '0;
    end else if (load_i) begin
      addr_q <= {col_i, row_i};
      ph_q   <= ph_i;
    end
  end

  // the first symbol of a hit comes straight from the FIFO head
  assign addr_src = load_i ? {col_i, row_i} : addr_q;
  assign ph_src   = load_i ? ph_i : ph_q;

  for (genvar d = 0; d < ADDR_DIGITS; d++) begin : g_digit
    assign digit[d] = addr_src[ADDR_W-1-d*DIGIT_W -: DIGIT_W];
  end

  always_comb begin
    valid_o = 1'b0;
    kind_o  = SYM_UBLACK;
    data_o  = '0;
    if (state_i == ST_HDR) begin
      valid_o = 1'b1;
      unique case (phase_i)
        PHASE_W'(0): kind_o = SYM_UBLACK;
        PHASE_W'(1): kind_o = SYM_BLACK;
        default:     kind_o = SYM_LEVREF;
      endcase
    end else if (state_i == ST_HIT) begin
      valid_o = 1'b1;
      if (phase_i < PHASE_W'(ADDR_DIGITS)) begin
        kind_o = SYM_ADDR;
        for (int d = 0; d < ADDR_DIGITS; d++) begin
          if (phase_i == PHASE_W'(d)) data_o = {{(PH_W-DIGIT_W){1'b0}}, digit[d]};
        end
      end else begin
        kind_o = SYM_PULSE;
        data_o = ph_src;
      end
    end
  end

  // R3: address digit symbols never use the upper data bits
  assert_digit_narrow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == SYM_ADDR) |-> (data_o[PH_W-1:DIGIT_W] == '0));
endmodule

// File: rtl/pix_token_serializer.sv
module pix_token_serializer
  import pxs_pkg::*;
#(
  parameter int COL_DIGITS = 2,
  parameter int ROW_DIGITS = 3,
  parameter int DIGIT_W    = 3,
  parameter int PH_W       = 8,
  localparam int COL_W    = COL_DIGITS * DIGIT_W,
  localparam int ROW_W    = ROW_DIGITS * DIGIT_W,
  localparam int HIT_SYMS = COL_DIGITS + ROW_DIGITS + 1,
  localparam int SEQ_LEN  = (HIT_SYMS > HDR_LEN) ? HIT_SYMS : HDR_LEN,
  localparam int PHASE_W  = $clog2(SEQ_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_in_i,
  input  logic             fifo_empty_i,
  input  logic [COL_W-1:0] fifo_col_i,
  input  logic [ROW_W-1:0] fifo_row_i,
  input  logic [PH_W-1:0]  fifo_ph_i,
  output logic             fifo_rd_o,
  output logic             sym_valid_o,
  output logic [2:0]       sym_kind_o,
  output logic [PH_W-1:0]  sym_data_o,
  output logic             tok_out_o
);
  logic               rst_n;
  seq_state_e         state;
  logic [PHASE_W-1:0] phase;
  logic               load;
  logic               busy;
  sym_kind_e          kind;

  pxs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  pxs_sequencer #(.HIT_SYMS(HIT_SYMS), .PHASE_W(PHASE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .tok_in_i     (tok_in_i),
    .fifo_empty_i (fifo_empty_i),
    .state_o      (state),
    .phase_o      (phase),
    .load_o       (load),
    .busy_o       (busy),
    .tok_out_o    (tok_out_o)
  );

  pxs_hit_slicer #(
    .COL_DIGITS(COL_DIGITS), .ROW_DIGITS(ROW_DIGITS),
    .DIGIT_W(DIGIT_W), .PH_W(PH_W), .PHASE_W(PHASE_W)
  ) u_slice (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .state_i (state),
    .phase_i (phase),
    .load_i  (load),
    .col_i   (fifo_col_i),
    .row_i   (fifo_row_i),
    .ph_i    (fifo_ph_i),
    .valid_o (sym_valid_o),
    .kind_o  (kind),
    .data_o  (sym_data_o)
  );

  assign sym_kind_o = kind;
  assign fifo_rd_o  = load;

  // R2: an accepted token is followed by the ultra-black marker
  assert_hdr_start_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tok_in_i && !busy) |=> (sym_valid_o && sym_kind_o == SYM_UBLACK));

  // R7: a token seen while busy never opens a new header
  assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tok_in_i && busy) |=> !(sym_valid_o && sym_kind_o == SYM_UBLACK));

  // R6: token-out is quiet on the symbol stream and follows a symbol
  assert_tok_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    tok_out_o |-> (!sym_valid_o && $past(sym_valid_o)));

  // R5: no pop from an empty FIFO
  assert_pop_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i);
endmodule

// File: tb/pix_token_serializer_tb.sv
module pix_token_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RING       = 64;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       tok_in;
  logic       fifo_empty;
  logic [5:0] fifo_col;
  logic [8:0] fifo_row;
  logic [7:0] fifo_ph;
  logic       fifo_rd;
  logic       sym_valid;
  logic [2:0] sym_kind;
  logic [7:0] sym_data;
  logic       tok_out;

  int mcol [RING];
  int mrow [RING];
  int mph  [RING];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int base   = 0;
  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_token_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tok_in_i(tok_in),
    .fifo_empty_i(fifo_empty), .fifo_col_i(fifo_col), .fifo_row_i(fifo_row),
    .fifo_ph_i(fifo_ph), .fifo_rd_o(fifo_rd), .sym_valid_o(sym_valid),
    .sym_kind_o(sym_kind), .sym_data_o(sym_data), .tok_out_o(tok_out)
  );

  // show-ahead FIFO model
  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_col   = 6'(mcol[rd_ptr % RING]);
  assign fifo_row   = 9'(mrow[rd_ptr % RING]);
  assign fifo_ph    = 8'(mph[rd_ptr % RING]);

  always @(posedge clk) begin
    if (fifo_rd && !fifo_empty) rd_ptr <= rd_ptr + 1;
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_hit(input int c, input int r, input int p);
    mcol[wr_ptr % RING] = c % 64;
    mrow[wr_ptr % RING] = r % 512;
    mph[wr_ptr % RING]  = p % 256;
    wr_ptr++;
  endtask

  // expected symbol j (0..5) of bench hit idx
  function automatic int exp_data(input int idx, input int j);
    int c = mcol[idx % RING];
    int r = mrow[idx % RING];
    case (j)
      0: return c / 8;
      1: return c % 8;
      2: return r / 64;
      3: return (r / 8) % 8;
      4: return r % 8;
      default: return mph[idx % RING];
    endcase
  endfunction

  task automatic readout(input int n, input bit inject, input bit append);
    int total;
    total = 3 + 6 * n;
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
    for (int k = 0; k < total; k++) begin
      check(int'(sym_valid), 1, "R8 valid during symbol");
      if (k < 3) begin
        check(int'(sym_kind), k, "R2 header kind");
        check(int'(sym_data), 0, "R2 header data");
        check(int'(fifo_rd), 0, "R5 no pop in header");
      end else begin
        int h = (k - 3) / 6;
        int j = (k - 3) % 6;
        check(int'(sym_kind), (j < 5) ? 3 : 4, (j < 5) ? "R3 digit kind" : "R4 pulse kind");
        check(int'(sym_data), exp_data(base + h, j), (j < 5) ? "R3 digit value" : "R4 pulse value");
        check(int'(fifo_rd), (j == 0) ? 1 : 0, "R5 pop on first hit symbol");
      end
      check(int'(tok_out), 0, "R6 no token during symbols");
      if (append && k == 4) put_hit(45, 300, 129);
      if (inject && (k == 7 || k == 1)) tok_in = 1'b1;
      else tok_in = 1'b0;
      @(negedge clk);
    end
    check(int'(tok_out), 1, "R6 token after last symbol");
    check(int'(sym_valid), 0, "R6 valid low at token");
    check(int'(fifo_rd), 0, "R5 stop on empty");
    tok_in = inject;
    @(negedge clk);
    tok_in = 1'b0;
    check(int'(tok_out), 0, "R6 single-cycle token");
    for (int q = 0; q < 4; q++) begin
      check(int'(sym_valid), 0, "R7 no restart from busy token");
      @(negedge clk);
    end
    base += n;
  endtask

  initial begin
    rst_ni = 1'b0;
    tok_in = 1'b0;
    for (int i = 0; i < RING; i++) begin
      mcol[i] = 0; mrow[i] = 0; mph[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(int'(sym_valid), 0, "R1 reset valid");
    check(int'(tok_out), 0, "R1 reset token");
    check(int'(fifo_rd), 0, "R1 reset pop");
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(int'(sym_valid), 0, "R1 idle valid");
    check(int'(tok_out), 0, "R1 idle token");

    readout(0, 0, 0);                                    // R5 R6 header only
    put_hit(63, 511, 255); readout(1, 0, 0);             // R3 R4 all ones
    put_hit(0, 0, 0); put_hit(9, 73, 1); readout(2, 0, 0);
    for (int i = 0; i < 5; i++) put_hit(i * 13, i * 101, i * 50 + 7);
    readout(5, 0, 0);
    for (int i = 0; i < 64; i++) put_hit(i, i * 37, i * 11 + 3);   // column sweep
    readout(64, 0, 0);
    for (int b = 0; b < 8; b++) begin                              // row sweep
      for (int i = 0; i < 64; i++) put_hit(i * 5 + b, b * 64 + i, 255 - i * 3 - b);
      readout(64, 0, 0);
    end
    for (int i = 0; i < 3; i++) put_hit(i + 20, i + 200, i + 90);
    readout(3, 1, 0);                                    // R7 busy tokens
    put_hit(7, 8, 9); put_hit(10, 11, 12);
    readout(3, 0, 1);                                    // R9 appended hit

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule